// File: doc/BRIEF.md
# Sprite Table Bulk Copy Engine

This block fills the sprite attribute memory from a 160-byte page of system memory. The processor starts a copy by writing one byte, the page number, to a control input. The source then runs from page times 0x100 up to page times 0x100 plus 0x9F. The destination is always the window from 0xFE00 to 0xFE9F. The engine moves one byte per machine cycle. Machine cycles arrive as a single-clock tick pulse.

A copy passes through three states. A control write puts the engine in a waiting state. The next tick starts the transfer, and from then on every tick issues one source read. System memory answers after a fixed number of clocks. Each returned byte is written into sprite memory at the matching offset. The busy output is high only while the transfer runs, and the access arbiter uses it to block the processor from sprite memory. A new control write during a copy restarts it from the new page and discards any reads still in flight.

Top module: `sprite_copy_engine`

## Requirements
- R1: After a synchronous active-low reset, including one during a copy, busy, src_rd_req and oam_wr_en are low. Ticks that follow the reset issue no read.
- R2: A control write puts the engine in the waiting state with busy low. The first tick after that raises busy on the clock edge that samples the tick.
- R3: While transferring, each tick issues one src_rd_req pulse in the cycle after it. The k-th request of a copy (k = 0..159) carries address page*0x100 + k. No request is issued outside the transferring state.
- R4: The byte returned RD_LAT cycles after the k-th request is written with oam_wr_en at address 0xFE00 + k. Writes come in increasing k.
- R5: Exactly 160 writes are made per copy. Busy falls in the cycle after the write to 0xFE9F. Later ticks issue no read and no write.
- R6: A control write during a transfer restarts the copy from the new page at k = 0. No byte from a read issued before the restart is written.
- R7: Ticks while idle have no effect on any output.
- R8: Busy is never high in the cycle after a control write, and oam_wr_en is high only while busy is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr | input | 1 | One-cycle strobe: control register write |
| cfg_page | input | 8 | Source page number (high address byte) |
| mc_tick | input | 1 | One-cycle pulse per machine cycle |
| src_rd_req | output | 1 | Source read request pulse |
| src_rd_addr | output | 16 | Source read address |
| src_rd_data | input | 8 | Read data, valid RD_LAT cycles after the request |
| oam_wr_en | output | 1 | Sprite memory write strobe |
| oam_wr_addr | output | 16 | Sprite memory write address |
| oam_wr_data | output | 8 | Sprite memory write data |
| busy | output | 1 | High while transferring |

## Verification
The assertions rely on three properties of the inputs. mc_tick and cfg_wr are single-cycle strobes. mc_tick is low during reset. src_rd_data holds the answer to a request exactly RD_LAT cycles after that request. The bench supplies this with a memory model that is a shift register RD_LAT deep. The model returns a computed byte for every address, so a misplaced or stale byte shows up as a data mismatch. The bench drives ticks at least two cycles apart and writes the control input only as one-cycle pulses, so the stimulus stays within these assumptions.

// File: rtl/scb_pkg.sv
// Package: shared types for the sprite table copy engine.
// Assumes nothing beyond a two-bit state encoding.
package scb_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_PEND = 2'd1,
        ST_XFER = 2'd2
    } scb_state_e;

endpackage

// File: rtl/scb_ctrl_fsm.sv
// Module: sequencing for the copy engine. Holds the state, the source
// page and the issue counter, and registers one read request per tick
// while transferring. Assumes ticks and control writes are one-cycle
// strobes. A control write takes priority over every other event.
module scb_ctrl_fsm
    import scb_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int PAGE_W = 8,
    parameter int SPAN   = 160,
    localparam int CNT_W = $clog2(SPAN + 1),
    localparam int IDX_W = $clog2(SPAN),
    localparam int LOW_W = ADDR_W - PAGE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic [PAGE_W-1:0] cfg_page,
    input  logic              tick,
    input  logic              last_wr,
    output scb_state_e        state,
    output logic              rd_req,
    output logic [ADDR_W-1:0] rd_addr,
    output logic [IDX_W-1:0]  rd_idx
);

    logic [PAGE_W-1:0] page_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [ADDR_W-1:0] base_addr;
    logic              can_issue;

    // Page base address and whether bytes remain to be issued
    always_comb begin
        base_addr = {page_q, {LOW_W{1'b0}}};
        can_issue = (cnt_q < CNT_W'(SPAN));
    end

    // State, counter and registered read request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            page_q  <= '0;
            cnt_q   <= '0;
            rd_req  <= 1'b0;
            rd_addr <= '0;
            rd_idx  <= '0;
        end else begin
            rd_req <= 1'b0;
            if (cfg_wr) begin
                state  <= ST_PEND;
                page_q <= cfg_page;
                cnt_q  <= '0;
            end else begin
                case (state)
                    ST_PEND: begin
                        if (tick) begin
                            state <= ST_XFER;
                        end
                    end
                    ST_XFER: begin
                        if (tick && can_issue) begin
                            rd_req  <= 1'b1;
                            rd_addr <= base_addr + ADDR_W'(cnt_q);
                            rd_idx  <= IDX_W'(cnt_q);
                            cnt_q   <= cnt_q + CNT_W'(1);
                        end
                        if (last_wr) begin
                            state <= ST_IDLE;
                            cnt_q <= '0;
                        end
                    end
                    default: begin
                        state <= ST_IDLE;
                    end
                endcase
            end
        end
    end

endmodule

// File: rtl/scb_rd_track.sv
// Module: delay line that follows each read request through the fixed
// memory latency. It carries a valid bit and the byte index. Assumes the
// memory returns data exactly RD_LAT cycles after the request cycle. A
// flush drops every entry still in flight.
module scb_rd_track #(
    parameter int RD_LAT = 2,
    parameter int IDX_W  = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             req,
    input  logic [IDX_W-1:0] req_idx,
    output logic             ret_vld,
    output logic [IDX_W-1:0] ret_idx
);

    logic [RD_LAT-1:0] vld_q;
    logic [IDX_W-1:0]  idx_q [RD_LAT];

    // First stage captures the request issued in the previous cycle
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            vld_q[0] <= 1'b0;
            idx_q[0] <= '0;
        end else begin
            vld_q[0] <= req;
            idx_q[0] <= req_idx;
        end
    end

    // Remaining stages shift the tracked entry toward the output
    for (genvar g = 1; g < RD_LAT; g++) begin : g_stage
        always_ff @(posedge clk) begin
            if (!rst_n || flush) begin
                vld_q[g] <= 1'b0;
                idx_q[g] <= '0;
            end else begin
                vld_q[g] <= vld_q[g-1];
                idx_q[g] <= idx_q[g-1];
            end
        end
    end

    // Output of the last stage lines up with the returned data
    always_comb begin
        ret_vld = vld_q[RD_LAT-1];
        ret_idx = idx_q[RD_LAT-1];
    end

endmodule

// File: rtl/scb_oam_writer.sv
// Module: registers each returned byte into a sprite memory write at the
// fixed destination base plus the byte index. It flags the write of the
// final index. Assumes indices arrive in increasing order.
module scb_oam_writer #(
    parameter int              ADDR_W    = 16,
    parameter int              DATA_W    = 8,
    parameter int              SPAN      = 160,
    parameter logic [ADDR_W-1:0] DEST_BASE = 16'hFE00,
    localparam int             IDX_W     = $clog2(SPAN)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              ret_vld,
    input  logic [IDX_W-1:0]  ret_idx,
    input  logic [DATA_W-1:0] ret_data,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic              last_wr
);

    logic [IDX_W-1:0] idx_q;

    // Write register: one strobe per returned byte
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wr_en   <= 1'b0;
            wr_addr <= DEST_BASE;
            wr_data <= '0;
            idx_q   <= '0;
        end else begin
            wr_en <= ret_vld;
            if (ret_vld) begin
                wr_addr <= DEST_BASE + ADDR_W'(ret_idx);
                wr_data <= ret_data;
                idx_q   <= ret_idx;
            end
        end
    end

    // Final byte of the span is on the write port this cycle
    always_comb begin
        last_wr = wr_en && (idx_q == IDX_W'(SPAN - 1));
    end

endmodule

// File: rtl/sprite_copy_engine.sv
// Module: top of the sprite table bulk copy engine. A control write picks
// a source page. The next tick starts the transfer, and each later tick
// copies one byte into sprite memory. Busy covers the transferring state
// only. Assumes a fixed-latency source read port and one-cycle strobes.
module sprite_copy_engine
    import scb_pkg::*;
#(
    parameter int              ADDR_W    = 16,
    parameter int              DATA_W    = 8,
    parameter int              PAGE_W    = 8,
    parameter int              SPAN      = 160,
    parameter int              RD_LAT    = 2,
    parameter logic [ADDR_W-1:0] DEST_BASE = 16'hFE00,
    localparam int             IDX_W     = $clog2(SPAN)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic [PAGE_W-1:0] cfg_page,
    input  logic              mc_tick,
    output logic              src_rd_req,
    output logic [ADDR_W-1:0] src_rd_addr,
    input  logic [DATA_W-1:0] src_rd_data,
    output logic              oam_wr_en,
    output logic [ADDR_W-1:0] oam_wr_addr,
    output logic [DATA_W-1:0] oam_wr_data,
    output logic              busy
);

    scb_state_e       state;
    logic [IDX_W-1:0] req_idx;
    logic             ret_vld;
    logic [IDX_W-1:0] ret_idx;
    logic             last_wr;

    scb_ctrl_fsm #(
        .ADDR_W (ADDR_W),
        .PAGE_W (PAGE_W),
        .SPAN   (SPAN)
    ) fsm_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_wr   (cfg_wr),
        .cfg_page (cfg_page),
        .tick     (mc_tick),
        .last_wr  (last_wr),
        .state    (state),
        .rd_req   (src_rd_req),
        .rd_addr  (src_rd_addr),
        .rd_idx   (req_idx)
    );

    scb_rd_track #(
        .RD_LAT (RD_LAT),
        .IDX_W  (IDX_W)
    ) track_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .flush   (cfg_wr),
        .req     (src_rd_req),
        .req_idx (req_idx),
        .ret_vld (ret_vld),
        .ret_idx (ret_idx)
    );

    scb_oam_writer #(
        .ADDR_W    (ADDR_W),
        .DATA_W    (DATA_W),
        .SPAN      (SPAN),
        .DEST_BASE (DEST_BASE)
    ) writer_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .flush    (cfg_wr),
        .ret_vld  (ret_vld),
        .ret_idx  (ret_idx),
        .ret_data (src_rd_data),
        .wr_en    (oam_wr_en),
        .wr_addr  (oam_wr_addr),
        .wr_data  (oam_wr_data),
        .last_wr  (last_wr)
    );

    // Busy flag for the access arbiter: transferring state only
    always_comb begin
        busy = (state == ST_XFER);
    end

endmodule

// File: rtl/sprite_copy_engine_chk.sv
// Module: property checker for the copy engine, bound to the top.
// Assumes one-cycle tick and control strobes, with tick low in reset.
module sprite_copy_engine_chk #(
    parameter int              ADDR_W    = 16,
    parameter int              SPAN      = 160,
    parameter logic [ADDR_W-1:0] DEST_BASE = 16'hFE00
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_wr,
    input logic              mc_tick,
    input logic              src_rd_req,
    input logic [ADDR_W-1:0] src_rd_addr,
    input logic              oam_wr_en,
    input logic [ADDR_W-1:0] oam_wr_addr,
    input logic              busy
);

    localparam logic [ADDR_W-1:0] DEST_LAST = DEST_BASE + ADDR_W'(SPAN - 1);

    AST_REQ_AFTER_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        src_rd_req |-> $past(mc_tick)); // R3

    AST_REQ_IN_SPAN: assert property (@(posedge clk) disable iff (!rst_n)
        src_rd_req |-> (src_rd_addr[7:0] <= 8'(SPAN - 1))); // R3

    AST_WR_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        oam_wr_en |-> (oam_wr_addr >= DEST_BASE && oam_wr_addr <= DEST_LAST)); // R4

    AST_BUSY_RISE_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(mc_tick)); // R2

    AST_IDLE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        (oam_wr_en && oam_wr_addr == DEST_LAST && !cfg_wr) |=> !busy); // R5

    AST_NOT_BUSY_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr |=> !busy); // R8

    AST_WR_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        oam_wr_en |-> busy); // R8

endmodule

bind sprite_copy_engine sprite_copy_engine_chk #(
    .ADDR_W    (ADDR_W),
    .SPAN      (SPAN),
    .DEST_BASE (DEST_BASE)
) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_wr      (cfg_wr),
    .mc_tick     (mc_tick),
    .src_rd_req  (src_rd_req),
    .src_rd_addr (src_rd_addr),
    .oam_wr_en   (oam_wr_en),
    .oam_wr_addr (oam_wr_addr),
    .busy        (busy)
);

// File: tb/sprite_copy_engine_tb_top.sv
// Bench: a table of (page, tick gap) copies, then directed tests for
// reset, idle ticks and restart. The memory model returns a computed byte.
module sprite_copy_engine_tb_top;

    localparam int RD_LAT = 2;
    localparam int SPAN   = 160;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [7:0]  cfg_page = 8'h00;
    logic        mc_tick = 1'b0;
    logic        src_rd_req;
    logic [15:0] src_rd_addr;
    logic [7:0]  src_rd_data;
    logic        oam_wr_en;
    logic [15:0] oam_wr_addr;
    logic [7:0]  oam_wr_data;
    logic        busy;

    int n_chk = 0, n_fail = 0;
    int req_cnt = 0, req_bad = 0, wr_cnt = 0, wr_bad = 0;
    logic [15:0] base = 16'h0000;
    bit done = 1'b0;

    // 50 MHz clock
    always #10 clk = ~clk;

    sprite_copy_engine #(.RD_LAT(RD_LAT)) dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_page(cfg_page),
        .mc_tick(mc_tick), .src_rd_req(src_rd_req), .src_rd_addr(src_rd_addr),
        .src_rd_data(src_rd_data), .oam_wr_en(oam_wr_en),
        .oam_wr_addr(oam_wr_addr), .oam_wr_data(oam_wr_data), .busy(busy)
    );

    function automatic logic [7:0] mem_byte(input logic [15:0] a);
        return a[7:0] ^ {a[11:8], a[15:12]} ^ 8'h5A;
    endfunction

    // Fixed-latency memory model: shift register of request addresses
    logic [15:0] lat_q [RD_LAT];
    always @(posedge clk) begin
        lat_q[0] <= src_rd_addr;
        for (int i = 1; i < RD_LAT; i++) lat_q[i] <= lat_q[i-1];
    end
    assign src_rd_data = mem_byte(lat_q[RD_LAT-1]);

    // Monitor: compare every request and write with the expected sequence
    always @(negedge clk) begin
        if (rst_n) begin
            if (src_rd_req) begin
                if (src_rd_addr != base + 16'(req_cnt)) req_bad++;
                req_cnt++;
            end
            if (oam_wr_en) begin
                if (oam_wr_addr != 16'hFE00 + 16'(wr_cnt) ||
                    oam_wr_data != mem_byte(base + 16'(wr_cnt))) wr_bad++;
                wr_cnt++;
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic clr_counts();
        req_cnt = 0; req_bad = 0; wr_cnt = 0; wr_bad = 0;
    endtask

    task automatic ctrl_pulse(input logic [7:0] pg);
        @(posedge clk); #2 cfg_wr = 1'b1; cfg_page = pg;
        @(posedge clk); #2 cfg_wr = 1'b0;
        base = {pg, 8'h00};
        clr_counts();
    endtask

    task automatic tick(input int gap);
        @(posedge clk); #2 mc_tick = 1'b1;
        @(posedge clk); #2 mc_tick = 1'b0;
        repeat (gap - 1) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic run_copy(input logic [7:0] pg, input int gap);
        ctrl_pulse(pg);
        chk(busy == 1'b0, "R2 pending busy", int'(busy), 0);
        chk(busy == 1'b0, "R8 no busy after control write", int'(busy), 0);
        tick(gap);
        chk(busy == 1'b1, "R2 busy after first tick", int'(busy), 1);
        for (int t = 0; t < 400 && req_cnt < SPAN; t++) tick(gap);
        for (int t = 0; t < 20 && busy; t++) @(negedge clk);
        chk(req_cnt == SPAN, "R3 request count", req_cnt, SPAN);
        chk(req_bad == 0, "R3 request address", req_bad, 0);
        chk(wr_cnt == SPAN, "R5 write count", wr_cnt, SPAN);
        chk(wr_bad == 0, "R4 write address/data", wr_bad, 0);
        chk(busy == 1'b0, "R5 busy after last write", int'(busy), 0);
        tick(gap); tick(gap);
        repeat (RD_LAT + 3) @(negedge clk);
        chk(req_cnt == SPAN && wr_cnt == SPAN, "R5 no access after end",
            req_cnt + wr_cnt, 2 * SPAN);
    endtask

    // Stimulus table: {page, tick gap}
    localparam logic [15:0] VEC [4] = '{16'hAB03, 16'h0001, 16'hFF04, 16'h3C02};

    initial begin
        repeat (3) @(posedge clk);
        #2;
        chk(!busy && !src_rd_req && !oam_wr_en, "R1 reset outputs",
            int'({busy, src_rd_req, oam_wr_en}), 0);
        rst_n = 1'b1;
        clr_counts();
        // Idle ticks do nothing
        for (int i = 0; i < 5; i++) tick(2);
        chk(req_cnt == 0 && wr_cnt == 0 && !busy, "R7 idle ticks", req_cnt + wr_cnt, 0);

        for (int v = 0; v < 4; v++) run_copy(VEC[v][15:8], int'(VEC[v][7:0]));

        // Restart during a transfer with a read in flight
        ctrl_pulse(8'h12);
        for (int i = 0; i < 12; i++) tick(3);
        @(posedge clk); #2 mc_tick = 1'b1;
        @(posedge clk); #2 mc_tick = 1'b0;
        run_copy(8'h80, 3);
        chk(wr_bad == 0 && wr_cnt == SPAN, "R6 restart from new page", wr_bad, 0);

        // Reset in the middle of a transfer
        ctrl_pulse(8'h55);
        for (int i = 0; i < 20; i++) tick(2);
        @(posedge clk); #2 rst_n = 1'b0;
        @(posedge clk); @(posedge clk); #2;
        chk(!busy && !src_rd_req && !oam_wr_en, "R1 outputs after mid-copy reset",
            int'({busy, src_rd_req, oam_wr_en}), 0);
        rst_n = 1'b1;
        clr_counts();
        for (int i = 0; i < 4; i++) tick(2);
        repeat (RD_LAT + 2) @(negedge clk);
        chk(req_cnt == 0 && wr_cnt == 0, "R1 no reads after reset", req_cnt + wr_cnt, 0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule